// File: doc/BRIEF.md
# Grid-Aligned Port Wait Generator

This block sits beside a Z80-style CPU and holds its active-low WAIT line for I/O transfers aimed at the system controller's own ports. The controller serves its ports on a repeating 8-clock access grid. The block counts that grid itself with a free-running phase counter that runs at the CPU clock and returns to zero on a sync pulse. When an I/O transfer to a controller port begins, the block computes how many extra clocks are needed so that the nominal 4-clock port access ends on a grid boundary. It then holds WAIT low for exactly that many clocks.

Transfers to any other port, and interrupt-acknowledge cycles, pass through with normal timing. Nothing else affects the stretch: display position, border and memory traffic play no part. Software that already issues controller-port accesses in step with the grid, spaced by multiples of 8 clocks, is delayed only on its first access.

Top module: `io_grid_wait`

## Requirements
- R1: During reset and in the cycle after it, `wait_n_o` is high. The clock edge that follows the release of reset sees grid phase 0.
- R2: A transfer is stretched only when `addr_i[7:3]` is 5'b11111 (ports F8h to FFh). Any other address gives no wait clocks.
- R3: A transfer is stretched only when `m1_n_i` is high and at least one of `rd_n_i` / `wr_n_i` is low at the edge where `iorq_n_i` is first seen low. Interrupt-acknowledge cycles (`m1_n_i` low) and cycles with no strobe are never stretched.
- R4: The number of wait clocks is (8 - ((p + 4) mod 8)) mod 8. Here p is the grid phase seen at the edge where the transfer is detected. The count therefore ranges from 0 to 7, and phase 0 gives 4.
- R5: The wait clocks form one unbroken low run on `wait_n_o`. The run starts in the cycle after the detecting edge, and the register releases it so that the access ends on a grid boundary.
- R6: A transfer detected at phase 4 receives no wait clocks. In a run of controller-port transfers spaced by multiples of 8 clocks, only a misaligned first one is delayed.
- R7: A clock edge that samples `sync_i` high returns the grid to zero, so the next edge sees phase 0.
- R8: Each high-to-low transition of `iorq_n_i` causes at most one stretch. Holding `iorq_n_i` low after the stretch does not start another.
- R9: Asserting reset while a stretch is in progress ends it, so `wait_n_o` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU clock, one edge per CPU clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Returns the grid phase counter to zero |
| iorq_n_i | input | 1 | Active-low I/O request |
| m1_n_i | input | 1 | Active-low opcode-fetch/acknowledge marker |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| addr_i | input | ADDR_W | Low address byte of the port |
| wait_n_o | output | 1 | Active-low registered WAIT to the CPU |

## Verification
The checker looks at every cycle. It confirms that each falling edge of WAIT traces back to a fresh I/O request that was decoded as a controller port with a valid strobe and M1 high. It also confirms that a low run never reaches a full grid period, and that, when no sync or reset intervened, each release lands where the access ends on a grid boundary. Only the bench scenarios can show the exact wait count for each of the eight start phases. The same holds for three further behaviours: phase 4 alignment across spaced back-to-back accesses, the effect of a sync pulse on a later access, and reset cancelling a stretch that is in progress.

// File: rtl/io_grid_wait_pkg.sv
package io_grid_wait_pkg;

  typedef enum logic [1:0] {
    XFER_NONE  = 2'd0,
    XFER_READ  = 2'd1,
    XFER_WRITE = 2'd2
  } xfer_kind_e;

  // Classify the strobe pair of a bus cycle; read wins if both are low.
  function automatic xfer_kind_e classify_xfer(input logic rd_n, input logic wr_n);
    if (!rd_n)      return XFER_READ;
    else if (!wr_n) return XFER_WRITE;
    else            return XFER_NONE;
  endfunction

endpackage

// File: rtl/io_grid_phase.sv
module io_grid_phase #(
  parameter int PHASE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               sync_i,
  output logic [PHASE_W-1:0] phase_o
);

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || sync_i) phase_q <= '0;
    else                 phase_q <= phase_q + 1'b1;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/io_grid_decode.sv
module io_grid_decode
  import io_grid_wait_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          MATCH_BITS = 5,
  parameter logic [7:0]  PORT_BASE  = 8'hF8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              iorq_n_i,
  input  logic              m1_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              start_o
);

  localparam int TOP = ADDR_W - 1;

  logic       iorq_prev_q;
  logic       port_hit;
  xfer_kind_e kind;

  generate
    if (MATCH_BITS == 0) begin : g_any_port
      assign port_hit = 1'b1;
    end else begin : g_match
      localparam logic [MATCH_BITS-1:0] REF = PORT_BASE[ADDR_W-1 -: MATCH_BITS];
      assign port_hit = (addr_i[TOP -: MATCH_BITS] == REF);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) iorq_prev_q <= 1'b1;
    else       iorq_prev_q <= iorq_n_i;
  end

  assign kind    = classify_xfer(rd_n_i, wr_n_i);
  assign start_o = iorq_prev_q && !iorq_n_i && m1_n_i && port_hit &&
                   (kind != XFER_NONE);

endmodule

// File: rtl/io_grid_stretch.sv
module io_grid_stretch #(
  parameter int PHASE_W  = 3,
  parameter int ACCESS_T = 4
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               wait_n_o
);

  localparam int GRID = 1 << PHASE_W;

  logic [PHASE_W-1:0] extra;
  logic [PHASE_W-1:0] left_q;
  logic               wait_n_q;

  // Clocks needed to push the access end up to the next grid boundary.
  assign extra = PHASE_W'(GRID - ((int'(phase_i) + ACCESS_T) % GRID));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      left_q   <= '0;
      wait_n_q <= 1'b1;
    end else if (start_i) begin
      left_q   <= extra;
      wait_n_q <= (extra == '0);
    end else if (left_q != '0) begin
      left_q   <= left_q - 1'b1;
      wait_n_q <= (left_q == PHASE_W'(1));
    end
  end

  assign wait_n_o = wait_n_q;

endmodule

// File: rtl/io_grid_wait.sv
module io_grid_wait #(
  parameter int         ADDR_W     = 8,
  parameter int         PHASE_W    = 3,
  parameter int         ACCESS_T   = 4,
  parameter int         MATCH_BITS = 5,
  parameter logic [7:0] PORT_BASE  = 8'hF8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sync_i,
  input  logic              iorq_n_i,
  input  logic              m1_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wait_n_o
);

  logic [PHASE_W-1:0] grid_ph;
  logic               start;

  io_grid_phase #(.PHASE_W(PHASE_W)) phase_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .sync_i (sync_i),
    .phase_o(grid_ph)
  );

  io_grid_decode #(
    .ADDR_W    (ADDR_W),
    .MATCH_BITS(MATCH_BITS),
    .PORT_BASE (PORT_BASE)
  ) decode_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .iorq_n_i(iorq_n_i),
    .m1_n_i  (m1_n_i),
    .rd_n_i  (rd_n_i),
    .wr_n_i  (wr_n_i),
    .addr_i  (addr_i),
    .start_o (start)
  );

  io_grid_stretch #(.PHASE_W(PHASE_W), .ACCESS_T(ACCESS_T)) stretch_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start),
    .phase_i (grid_ph),
    .wait_n_o(wait_n_o)
  );

endmodule

// File: rtl/io_grid_wait_chk.sv
module io_grid_wait_chk #(
  parameter int ADDR_W   = 8,
  parameter int PHASE_W  = 3,
  parameter int ACCESS_T = 4
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               sync_i,
  input logic               iorq_n_i,
  input logic               m1_n_i,
  input logic               rd_n_i,
  input logic               wr_n_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wait_n_o,
  input logic [PHASE_W-1:0] grid_ph
);

  localparam int GRID = 1 << PHASE_W;
  localparam logic [PHASE_W-1:0] END_PH = PHASE_W'((ACCESS_T + 1) % GRID);

  logic               rst_seen_q = 1'b0;
  logic               disturbed_q = 1'b1;
  logic [PHASE_W:0]   low_run_q = '0;

  always_ff @(posedge clk_i) begin
    rst_seen_q <= rst_i;
    if (rst_i || sync_i)  disturbed_q <= 1'b1;
    else if (wait_n_o)    disturbed_q <= 1'b0;
    if (rst_i || wait_n_o) low_run_q <= '0;
    else if (low_run_q != (PHASE_W+1)'(GRID)) low_run_q <= low_run_q + 1'b1;
  end

  // R1: WAIT is released in the cycle after any reset cycle.
  always_ff @(posedge clk_i) begin
    if (rst_seen_q) a_r1_idle_after_reset: assert (wait_n_o);
  end

  // R2: a stretch begins only for an address in the controller range.
  a_r2_port_range: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(wait_n_o) |-> ($past(addr_i[ADDR_W-1 -: 5]) == 5'h1F));

  // R3: a stretch needs M1 high and a strobe.
  a_r3_no_ack_stretch: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(wait_n_o) |-> ($past(m1_n_i) && (!$past(rd_n_i) || !$past(wr_n_i))));

  // R4: a low run never lasts a whole grid period.
  a_r4_bounded_run: assert property (@(posedge clk_i) disable iff (rst_i)
    low_run_q < (PHASE_W+1)'(GRID));

  // R5: an undisturbed release lands with the access ending on the grid.
  a_r5_release_on_grid: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(wait_n_o) && !disturbed_q) |-> (grid_ph == END_PH));

  // R8: a stretch starts only on a fresh high-to-low request edge.
  a_r8_fresh_request: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(wait_n_o) |-> (!$past(iorq_n_i) && $past(iorq_n_i, 2)));

endmodule

bind io_grid_wait io_grid_wait_chk #(
  .ADDR_W  (ADDR_W),
  .PHASE_W (PHASE_W),
  .ACCESS_T(ACCESS_T)
) chk_i (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .sync_i  (sync_i),
  .iorq_n_i(iorq_n_i),
  .m1_n_i  (m1_n_i),
  .rd_n_i  (rd_n_i),
  .wr_n_i  (wr_n_i),
  .addr_i  (addr_i),
  .wait_n_o(wait_n_o),
  .grid_ph (grid_ph)
);

// File: tb/io_grid_wait_tb.sv
module io_grid_wait_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync = 1'b0;
  logic       iorq_n = 1'b1;
  logic       m1_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] addr = 8'h00;
  logic       wait_n;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic [2:0] bph = 3'd0;  // grid phase the next edge will see (per R1/R7)

  always #10 clk = ~clk;  // 50 MHz

  io_grid_wait dut_i (
    .clk_i(clk), .rst_i(rst), .sync_i(sync), .iorq_n_i(iorq_n),
    .m1_n_i(m1_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .addr_i(addr),
    .wait_n_o(wait_n)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst || sync) bph <= 3'd0;
    else             bph <= bph + 3'd1;
  end

  // {addr[16:9], m1_n[8], rd_n[7], wr_n[6], phase[5:3], expected waits[2:0]}
  localparam logic [16:0] VEC [16] = '{
    {8'hF8, 1'b1, 1'b0, 1'b1, 3'd0, 3'd4},  // R4
    {8'hF9, 1'b1, 1'b0, 1'b1, 3'd1, 3'd3},  // R4
    {8'hFA, 1'b1, 1'b1, 1'b0, 3'd2, 3'd2},  // R4
    {8'hFB, 1'b1, 1'b0, 1'b1, 3'd3, 3'd1},  // R4
    {8'hFC, 1'b1, 1'b1, 1'b0, 3'd4, 3'd0},  // R6
    {8'hFD, 1'b1, 1'b0, 1'b1, 3'd5, 3'd7},  // R4
    {8'hFE, 1'b1, 1'b1, 1'b0, 3'd6, 3'd6},  // R4
    {8'hFF, 1'b1, 1'b0, 1'b1, 3'd7, 3'd5},  // R4
    {8'hF7, 1'b1, 1'b0, 1'b1, 3'd5, 3'd0},  // R2
    {8'h00, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0},  // R2
    {8'h7F, 1'b1, 1'b0, 1'b1, 3'd1, 3'd0},  // R2
    {8'hFE, 1'b0, 1'b1, 1'b1, 3'd5, 3'd0},  // R3 acknowledge
    {8'hF8, 1'b0, 1'b0, 1'b1, 3'd5, 3'd0},  // R3 M1 low
    {8'hF8, 1'b1, 1'b1, 1'b1, 3'd5, 3'd0},  // R3 no strobe
    {8'hFF, 1'b1, 1'b1, 1'b0, 3'd5, 3'd7},  // R4
    {8'hF8, 1'b1, 1'b1, 1'b0, 3'd0, 3'd4}   // R4
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts and ends at a falling clock edge.
  task automatic access(input logic [7:0] a, input logic m1, input logic rd,
                        input logic wr, input logic [2:0] ph, input int exp,
                        input string req);
    int n = 0;
    while (bph != ph) @(negedge clk);
    addr = a; m1_n = m1; rd_n = rd; wr_n = wr; iorq_n = 1'b0;
    @(negedge clk);
    while (!wait_n && n < 20) begin
      n++;
      @(negedge clk);
    end
    check(n == exp, req, n, exp);
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wait_n == 1'b1, "R1 wait high in reset", wait_n, 1);
    rst = 1'b0;
    @(negedge clk);
    check(wait_n == 1'b1, "R1 wait high after reset", wait_n, 1);
    // Phase 0 right after reset: first edge after release sees 0 (R1).
    access(8'hF8, 1'b1, 1'b0, 1'b1, 3'd1, 3, "R1 phase after reset");

    foreach (VEC[i]) begin
      access(VEC[i][16:9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:3],
             int'(VEC[i][2:0]), $sformatf("R4/R2/R3 vector %0d", i));
    end

    // R6: misaligned first, then aligned accesses at 16-clock spacing.
    access(8'hFE, 1'b1, 1'b0, 1'b1, 3'd1, 3, "R6 first misaligned");
    repeat (8) @(negedge clk);
    access(8'hFE, 1'b1, 1'b0, 1'b1, 3'd4, 0, "R6 second aligned");
    repeat (8) @(negedge clk);
    access(8'hFE, 1'b1, 1'b1, 1'b0, 3'd4, 0, "R6 third aligned");

    // R7: sync while the grid is at 3; the next edge must see phase 0.
    while (bph != 3'd3) @(negedge clk);
    sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
    access(8'hF9, 1'b1, 1'b0, 1'b1, 3'd0, 4, "R7 phase after sync");

    // R8 and R5: hold request low; one unbroken run, then no retrigger.
    begin
      int n = 0;
      int highs = 0;
      while (bph != 3'd6) @(negedge clk);
      addr = 8'hFA; rd_n = 1'b0; iorq_n = 1'b0;
      @(negedge clk);
      while (!wait_n && n < 20) begin n++; @(negedge clk); end
      check(n == 6, "R5 run length", n, 6);
      for (int k = 0; k < 20; k++) begin
        if (wait_n) highs++;
        @(negedge clk);
      end
      check(highs == 20, "R8 no retrigger", highs, 20);
      iorq_n = 1'b1; rd_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
    end

    // R9: reset in the middle of a 7-clock stretch.
    while (bph != 3'd5) @(negedge clk);
    addr = 8'hFD; rd_n = 1'b0; iorq_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(wait_n == 1'b0, "R9 stretch running", wait_n, 0);
    rst = 1'b1;
    @(negedge clk);
    check(wait_n == 1'b1, "R9 reset ends stretch", wait_n, 1);
    rst = 1'b0; iorq_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    access(8'hFB, 1'b1, 1'b0, 1'b1, 3'd2, 2, "R4 after reset");

    finish_run();
  end

endmodule